// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits behind the 16-bit write bus of a parallel NOR flash model. It turns bus writes into commands: some take a single bus write, others take a setup write followed by a confirm write. It selects what a read returns: array data, the status byte, or identifier words. It starts word programs, buffered programs, block erases and blank checks, and it changes the protection state of blocks. The array is a small register file with a lock flag and a lock-down flag for each block. A busy counter stands in for the time a program or erase takes.

Reads are combinational on the same address bus. The low byte of a write carries the command code and the upper byte is ignored for decoding. A status byte reports the ready flag, two suspend flags and three sticky error flags. A running program or erase can be suspended and resumed. While an operation is suspended, no new array operation is accepted.

Top module: `flcmd_ctrl`

## Requirements
- R1: After reset, reads return array data and every word reads FFFFh. The status byte reads 80h. Every block is locked and none is locked down, so an identifier read at in-block offset 2 returns 0001h.
- R2: Read-mode commands take effect from the next read and stay in force until another read-mode command. 70h selects the status byte on bits 7:0 with bits 15:8 zero. 90h selects identifier words: in-block offset 0 gives 0089h, offset 1 gives 8922h, offset 2 gives {lock-down, lock} of the addressed block on bits 1:0, and offset 5 gives the configuration word. 98h makes reads return zero. FFh selects array data. Every program, erase and blank-check setup also selects the status byte.
- R3: A write of 40h followed by a data write to an unlocked block ANDs the data into the addressed word, so a program can only clear bits.
- R4: Status bit 7 reads 0 for exactly OP_CYCLES read cycles after the write that starts an operation, and 1 afterwards. While an operation runs, only B0h and 70h have any effect.
- R5: E8h (or 80h) at an address fixes the target block. The next write gives N-1, where N is the number of words. The N data writes that follow are buffered. A final D0h programs all of them at once. A count above the block size sets status bits 4 and 5, and nothing is programmed.
- R6: While the count or the buffered words are being written, a write to an address outside the target block aborts the buffered program. It sets status bit 4 and leaves the array unchanged. FFh then returns reads to array data.
- R7: 20h followed by D0h at an unlocked block sets every word of that block to FFFFh.
- R8: A 60h setup followed by 01h locks the addressed block, by D0h unlocks it, and by 2Fh locks it down. A locked-down block ignores unlock until reset. A program to a locked block sets status bits 4 and 1; an erase of a locked block sets status bits 5 and 1. In both cases the array is unchanged.
- R9: BCh followed by D0h runs a blank check of the addressed block. It sets status bit 5 if any word of that block is not FFFFh, and it leaves reads in status mode.
- R10: After a two-write setup (20h, BCh, E8h-confirm or 60h), a second write carrying an unknown code sets status bits 4 and 5.
- R11: Error bits 5, 4 and 1 stay set until a 50h command clears them.
- R12: B0h during a running program sets status bit 2, and during a running erase sets status bit 6. Either way status bit 7 reads 1 and the busy count is frozen. D0h clears the suspend bit and the remaining count resumes.
- R13: While suspended, a BCh, 40h, E8h, 80h or 20h command sets status bits 4 and 5 and starts nothing.
- R14: 60h followed by 03h loads the configuration word from the address bus, zero-extended. It is readable at identifier offset 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address for writes and reads |
| bus_wdata | input | 16 | Write data; bits 7:0 carry command codes |
| bus_rdata | output | 16 | Read data selected by the current read mode |

## Verification
A wrong sequencer state shows on the next bus write. A confirm is then either taken as a fresh command or lands as a data word, and the error bits or the array contents read back wrong on the following read. A wrong read mode is visible on the very next read. A miscounted or unfrozen busy counter moves the cycle in which status bit 7 returns to 1, and the bench checks that flag on every cycle of an operation. A leaked lock state shows at once in the identifier lock word and in the lock-error bit of the next program or erase.

// File: rtl/flcmd_pkg.sv
// Shared types and command codes for the flash command sequencer.
// Assumes command codes are carried in the low byte of a 16-bit write.
package flcmd_pkg;
    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WP_DATA, ST_BP_COUNT, ST_BP_LOAD,
        ST_BP_CONF, ST_ER_CONF, ST_BC_CONF, ST_LK_CONF
    } cstate_e;

    typedef enum logic [1:0] {LK_NONE, LK_LOCK, LK_UNLOCK, LK_DOWN} lkop_e;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE, OP_BLANK} optype_e;

    localparam logic [7:0] C_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] C_RD_STATUS = 8'h70;
    localparam logic [7:0] C_CLR_STAT  = 8'h50;
    localparam logic [7:0] C_RD_IDENT  = 8'h90;
    localparam logic [7:0] C_RD_QUERY  = 8'h98;
    localparam logic [7:0] C_WORD_PROG = 8'h40;
    localparam logic [7:0] C_BUF_PROG  = 8'hE8;
    localparam logic [7:0] C_FAC_PROG  = 8'h80;
    localparam logic [7:0] C_ERASE     = 8'h20;
    localparam logic [7:0] C_BLANK     = 8'hBC;
    localparam logic [7:0] C_SUSPEND   = 8'hB0;
    localparam logic [7:0] C_CONFIRM   = 8'hD0;
    localparam logic [7:0] C_PROT      = 8'h60;
    localparam logic [7:0] C_PR_LOCK   = 8'h01;
    localparam logic [7:0] C_PR_DOWN   = 8'h2F;
    localparam logic [7:0] C_PR_CFG    = 8'h03;
endpackage

// File: rtl/flcmd_busy_timer.sv
// Busy counter standing in for array operation time.
// Loads CYCLES on start, counts down unless held, active while nonzero.
// Assumes start is never raised while the counter is active.
module flcmd_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load, freeze or count down the remaining operation time.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (start)                 cnt_q <= CW'(CYCLES);
        else if (!hold && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R12: a held counter keeps its value.
    a_r12_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/flcmd_store.sv
// Word array with per-block lock and lock-down flags.
// Program ANDs masked words into one block; erase sets one block to ones.
// Assumes the controller never programs or erases a locked block.
module flcmd_store #(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 4,
    localparam int BLK_W = ADDR_W - OFS_W,
    localparam int WPB   = 1 << OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [15:0]            rd_word,
    output logic                   rd_locked,
    output logic                   rd_down,
    input  logic [BLK_W-1:0]       sel_blk,
    output logic                   sel_locked,
    output logic                   sel_blank,
    input  logic                   prog_en,
    input  logic [WPB-1:0]         prog_mask,
    input  logic [WPB-1:0][15:0]   prog_data,
    input  logic                   erase_en,
    input  flcmd_pkg::lkop_e       lk_op
);
    import flcmd_pkg::*;

    localparam int NBLK  = 1 << BLK_W;
    localparam int NWORD = NBLK * WPB;

    logic [15:0]     words [NWORD];
    logic [NBLK-1:0] lock_v;
    logic [NBLK-1:0] down_v;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic lock_q, down_q;
        logic hit;
        assign hit = (sel_blk == BLK_W'(b));

        // Track protection state of this block.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q <= 1'b1;
                down_q <= 1'b0;
            end else if (hit) begin
                case (lk_op)
                    LK_LOCK:   lock_q <= 1'b1;
                    LK_UNLOCK: if (!down_q) lock_q <= 1'b0;
                    LK_DOWN:   begin lock_q <= 1'b1; down_q <= 1'b1; end
                    default:   ;
                endcase
            end
        end
        assign lock_v[b] = lock_q;
        assign down_v[b] = down_q;

        // R8: lock-down can only be left by reset and keeps the block locked.
        a_r8_down_holds: assert property (@(posedge clk) disable iff (!rst_n)
            down_q |=> (down_q && lock_q));

        for (genvar w = 0; w < WPB; w++) begin : g_word
            logic [15:0] word_q;
            // Erase to ones or clear bits by programming.
            always_ff @(posedge clk) begin
                if (!rst_n)                           word_q <= 16'hFFFF;
                else if (erase_en && hit)             word_q <= 16'hFFFF;
                else if (prog_en && hit && prog_mask[w]) word_q <= word_q & prog_data[w];
            end
            assign words[b*WPB + w] = word_q;
        end
    end

    assign rd_word    = words[rd_addr];
    assign rd_locked  = lock_v[rd_addr[ADDR_W-1:OFS_W]];
    assign rd_down    = down_v[rd_addr[ADDR_W-1:OFS_W]];
    assign sel_locked = lock_v[sel_blk];

    // Blank detect over every word of the selected block.
    always_comb begin
        sel_blank = 1'b1;
        for (int w = 0; w < WPB; w++) begin
            if (words[int'(sel_blk) * WPB + w] != 16'hFFFF) sel_blank = 1'b0;
        end
    end

    // R8: no array change reaches a locked block.
    a_r8_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |-> !lock_v[sel_blk]);
endmodule

// File: rtl/flcmd_ctrl.sv
// Command sequencer for a parallel NOR flash model (top).
// Decodes single and two-write commands from the low byte of bus writes,
// keeps the read mode, the sticky error flags and the suspend flags, and
// drives the word store and the busy timer. Assumes one write per cycle
// and combinational reads on the shared address bus.
module flcmd_ctrl #(
    parameter int          ADDR_W   = 8,
    parameter int          OFS_W    = 4,
    parameter int          OP_CYC   = 4,
    parameter logic [15:0] MFR_ID   = 16'h0089,
    parameter logic [15:0] DEV_ID   = 16'h8922,
    parameter logic [15:0] CFG_RST  = 16'hBFCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata
);
    import flcmd_pkg::*;

    localparam int BLK_W = ADDR_W - OFS_W;
    localparam int WPB   = 1 << OFS_W;

    cstate_e              st_q, st_d;
    rmode_e               mode_q, mode_d;
    optype_e              op_q, op_d;
    logic                 e_lock_q, e_lock_d;
    logic                 e_prog_q, e_prog_d;
    logic                 e_erase_q, e_erase_d;
    logic                 susp_p_q, susp_p_d;
    logic                 susp_e_q, susp_e_d;
    logic [BLK_W-1:0]     tgt_q, tgt_d;
    logic [OFS_W-1:0]     left_q, left_d;
    logic [WPB-1:0]       bmask_q, bmask_d;
    logic [WPB-1:0][15:0] bdata_q, bdata_d;
    logic [15:0]          cfg_q, cfg_d;

    logic [7:0]           cmd;
    logic [BLK_W-1:0]     bus_blk, sel_blk;
    logic [OFS_W-1:0]     bus_ofs;
    logic                 tmr_active, tmr_start, busy_run, susp_any;
    logic                 prog_en, erase_en, clr_hit;
    logic [WPB-1:0]       prog_mask;
    logic [WPB-1:0][15:0] prog_data;
    lkop_e                lk_op;
    logic [15:0]          rd_word;
    logic                 rd_locked, rd_down, sel_locked, sel_blank;
    logic [7:0]           status;

    assign cmd      = bus_wdata[7:0];
    assign bus_blk  = bus_addr[ADDR_W-1:OFS_W];
    assign bus_ofs  = bus_addr[OFS_W-1:0];
    assign susp_any = susp_p_q || susp_e_q;
    assign busy_run = tmr_active && !susp_any;
    assign sel_blk  = (st_q == ST_BP_CONF) ? tgt_q : bus_blk;

    flcmd_busy_timer #(.CYCLES(OP_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .hold(susp_any), .active(tmr_active)
    );

    flcmd_store #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) store_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_word(rd_word),
        .rd_locked(rd_locked), .rd_down(rd_down), .sel_blk(sel_blk),
        .sel_locked(sel_locked), .sel_blank(sel_blank), .prog_en(prog_en),
        .prog_mask(prog_mask), .prog_data(prog_data), .erase_en(erase_en), .lk_op(lk_op)
    );

    // Program strobes: one word from the bus or the whole buffer.
    always_comb begin
        if (st_q == ST_BP_CONF) begin
            prog_mask = bmask_q;
            prog_data = bdata_q;
        end else begin
            prog_mask = '0;
            prog_mask[bus_ofs] = 1'b1;
            for (int w = 0; w < WPB; w++) prog_data[w] = bus_wdata;
        end
    end

    // Command decode and next-state selection.
    always_comb begin
        st_d = st_q;  mode_d = mode_q;  op_d = op_q;
        e_lock_d = e_lock_q;  e_prog_d = e_prog_q;  e_erase_d = e_erase_q;
        susp_p_d = susp_p_q;  susp_e_d = susp_e_q;
        tgt_d = tgt_q;  left_d = left_q;  bmask_d = bmask_q;  bdata_d = bdata_q;
        cfg_d = cfg_q;
        prog_en = 1'b0;  erase_en = 1'b0;  lk_op = LK_NONE;
        tmr_start = 1'b0;  clr_hit = 1'b0;
        if (bus_we) begin
            if (busy_run) begin
                if (cmd == C_SUSPEND && op_q == OP_PROG)       susp_p_d = 1'b1;
                else if (cmd == C_SUSPEND && op_q == OP_ERASE) susp_e_d = 1'b1;
                else if (cmd == C_RD_STATUS)                   mode_d = RM_STATUS;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        case (cmd)
                            C_RD_ARRAY:  mode_d = RM_ARRAY;
                            C_RD_STATUS: mode_d = RM_STATUS;
                            C_RD_IDENT:  mode_d = RM_IDENT;
                            C_RD_QUERY:  mode_d = RM_QUERY;
                            C_CLR_STAT: begin
                                clr_hit = 1'b1;
                                e_lock_d = 1'b0;  e_prog_d = 1'b0;  e_erase_d = 1'b0;
                            end
                            C_CONFIRM: if (susp_any) begin
                                susp_p_d = 1'b0;  susp_e_d = 1'b0;  mode_d = RM_STATUS;
                            end
                            C_WORD_PROG, C_BUF_PROG, C_FAC_PROG, C_ERASE, C_BLANK: begin
                                mode_d = RM_STATUS;
                                tgt_d  = bus_blk;
                                if (susp_any) begin
                                    e_prog_d = 1'b1;  e_erase_d = 1'b1;
                                end else if (cmd == C_WORD_PROG) st_d = ST_WP_DATA;
                                else if (cmd == C_ERASE)          st_d = ST_ER_CONF;
                                else if (cmd == C_BLANK)          st_d = ST_BC_CONF;
                                else                              st_d = ST_BP_COUNT;
                            end
                            C_PROT:  st_d = ST_LK_CONF;
                            default: ;
                        endcase
                    end
                    ST_WP_DATA: begin
                        st_d = ST_IDLE;
                        if (sel_locked) begin
                            e_lock_d = 1'b1;  e_prog_d = 1'b1;
                        end else begin
                            prog_en = 1'b1;  tmr_start = 1'b1;  op_d = OP_PROG;
                        end
                    end
                    ST_BP_COUNT: begin
                        if (bus_blk != tgt_q) begin
                            e_prog_d = 1'b1;  st_d = ST_IDLE;
                        end else if (bus_wdata > 16'(WPB - 1)) begin
                            e_prog_d = 1'b1;  e_erase_d = 1'b1;  st_d = ST_IDLE;
                        end else begin
                            left_d = bus_wdata[OFS_W-1:0];  bmask_d = '0;  st_d = ST_BP_LOAD;
                        end
                    end
                    ST_BP_LOAD: begin
                        if (bus_blk != tgt_q) begin
                            e_prog_d = 1'b1;  st_d = ST_IDLE;
                        end else begin
                            bdata_d[bus_ofs] = bus_wdata;
                            bmask_d[bus_ofs] = 1'b1;
                            if (left_q == '0) st_d = ST_BP_CONF;
                            else              left_d = left_q - 1'b1;
                        end
                    end
                    ST_BP_CONF: begin
                        st_d = ST_IDLE;
                        if (cmd != C_CONFIRM) begin
                            e_prog_d = 1'b1;  e_erase_d = 1'b1;
                        end else if (sel_locked) begin
                            e_lock_d = 1'b1;  e_prog_d = 1'b1;
                        end else begin
                            prog_en = 1'b1;  tmr_start = 1'b1;  op_d = OP_PROG;
                        end
                    end
                    ST_ER_CONF: begin
                        st_d = ST_IDLE;
                        if (cmd != C_CONFIRM) begin
                            e_prog_d = 1'b1;  e_erase_d = 1'b1;
                        end else if (sel_locked) begin
                            e_lock_d = 1'b1;  e_erase_d = 1'b1;
                        end else begin
                            erase_en = 1'b1;  tmr_start = 1'b1;  op_d = OP_ERASE;
                        end
                    end
                    ST_BC_CONF: begin
                        st_d = ST_IDLE;
                        if (cmd != C_CONFIRM) begin
                            e_prog_d = 1'b1;  e_erase_d = 1'b1;
                        end else begin
                            if (!sel_blank) e_erase_d = 1'b1;
                            tmr_start = 1'b1;  op_d = OP_BLANK;
                        end
                    end
                    ST_LK_CONF: begin
                        st_d = ST_IDLE;
                        case (cmd)
                            C_PR_LOCK: lk_op = LK_LOCK;
                            C_CONFIRM: lk_op = LK_UNLOCK;
                            C_PR_DOWN: lk_op = LK_DOWN;
                            C_PR_CFG:  cfg_d = 16'(bus_addr);
                            default: begin
                                e_prog_d = 1'b1;  e_erase_d = 1'b1;
                            end
                        endcase
                    end
                    default: st_d = ST_IDLE;
                endcase
            end
        end
    end

    // State, mode, flags and buffer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;  mode_q <= RM_ARRAY;  op_q <= OP_NONE;
            e_lock_q <= 1'b0;  e_prog_q <= 1'b0;  e_erase_q <= 1'b0;
            susp_p_q <= 1'b0;  susp_e_q <= 1'b0;
            tgt_q <= '0;  left_q <= '0;  bmask_q <= '0;  bdata_q <= '0;
            cfg_q <= CFG_RST;
        end else begin
            st_q <= st_d;  mode_q <= mode_d;  op_q <= op_d;
            e_lock_q <= e_lock_d;  e_prog_q <= e_prog_d;  e_erase_q <= e_erase_d;
            susp_p_q <= susp_p_d;  susp_e_q <= susp_e_d;
            tgt_q <= tgt_d;  left_q <= left_d;  bmask_q <= bmask_d;  bdata_q <= bdata_d;
            cfg_q <= cfg_d;
        end
    end

    assign status = {!busy_run, susp_e_q, e_erase_q, e_prog_q, 1'b0, susp_p_q, e_lock_q, 1'b0};

    // Read data multiplexer driven by the current read mode.
    always_comb begin
        case (mode_q)
            RM_ARRAY:  bus_rdata = rd_word;
            RM_STATUS: bus_rdata = {8'h00, status};
            RM_IDENT: begin
                case (bus_ofs)
                    OFS_W'(0): bus_rdata = MFR_ID;
                    OFS_W'(1): bus_rdata = DEV_ID;
                    OFS_W'(2): bus_rdata = {14'b0, rd_down, rd_locked};
                    OFS_W'(5): bus_rdata = cfg_q;
                    default:   bus_rdata = 16'h0000;
                endcase
            end
            default:   bus_rdata = 16'h0000;
        endcase
    end

    // R4: no new operation starts over one still counting.
    a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |-> !tmr_active);
    // R11: the erase/sequence error flag holds until cleared.
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (e_erase_q && !clr_hit) |=> e_erase_q);
    // R12: at most one kind of suspension at a time.
    a_r12_one_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({susp_p_q, susp_e_q}));
    // R13: blank check while suspended yields a sequence error.
    a_r13_blank_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !busy_run && st_q == ST_IDLE && susp_any && cmd == C_BLANK)
        |=> (e_prog_q && e_erase_q));
endmodule

// File: tb/flcmd_ctrl_tb.sv
// Self-checking bench for the flash command sequencer.
module flcmd_ctrl_tb_top;
    localparam int CLK_P  = 10;
    localparam int OP_CYC = 4;
    localparam int NV     = 56;
    localparam logic [1:0] OW = 2'd0, OS = 2'd1, OR = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    flcmd_ctrl #(.ADDR_W(8), .OFS_W(4), .OP_CYC(OP_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Row: {kind, addr, data, requirement}; OW write, OS write then settle, OR read.
    localparam logic [33:0] VEC [NV] = '{
        {OW,8'h10,16'h0060,8'd8}, {OW,8'h10,16'h00D0,8'd8},   // R8 unlock block 1
        {OW,8'h20,16'h0060,8'd8}, {OW,8'h20,16'h00D0,8'd8},   // R8 unlock block 2
        {OW,8'h12,16'h0040,8'd3}, {OS,8'h12,16'hABCD,8'd3},   // R3 word program
        {OW,8'h00,16'h00FF,8'd2}, {OR,8'h12,16'hABCD,8'd3},
        {OW,8'h12,16'h0040,8'd3}, {OS,8'h12,16'hF0F0,8'd3},   // R3 AND semantics
        {OW,8'h00,16'h00FF,8'd2}, {OR,8'h12,16'hA0C0,8'd3},
        {OW,8'h00,16'h0070,8'd2}, {OR,8'h00,16'h0080,8'd2},   // R2 status mode
        {OW,8'h20,16'h00E8,8'd5}, {OW,8'h20,16'h0002,8'd5},   // R5 buffered, N=3
        {OW,8'h21,16'h1111,8'd5}, {OW,8'h25,16'h2222,8'd5},
        {OW,8'h2F,16'h3333,8'd5}, {OS,8'h20,16'h00D0,8'd5},
        {OW,8'h00,16'h00FF,8'd5}, {OR,8'h21,16'h1111,8'd5},
        {OR,8'h25,16'h2222,8'd5}, {OR,8'h2F,16'h3333,8'd5},
        {OR,8'h22,16'hFFFF,8'd5},
        {OW,8'h20,16'h0020,8'd7}, {OS,8'h20,16'h00D0,8'd7},   // R7 erase
        {OW,8'h00,16'h00FF,8'd7}, {OR,8'h21,16'hFFFF,8'd7},
        {OR,8'h2F,16'hFFFF,8'd7},
        {OW,8'h20,16'h00BC,8'd9}, {OS,8'h20,16'h00D0,8'd9},   // R9 blank pass
        {OR,8'h00,16'h0080,8'd9},
        {OW,8'h10,16'h00BC,8'd9}, {OS,8'h10,16'h00D0,8'd9},   // R9 blank fail
        {OR,8'h00,16'h00A0,8'd9},
        {OW,8'h00,16'h0050,8'd11}, {OR,8'h00,16'h0080,8'd11}, // R11 clear
        {OW,8'h00,16'h0090,8'd2}, {OR,8'h00,16'h0089,8'd2},   // R2 identifier
        {OR,8'h01,16'h8922,8'd2}, {OR,8'h12,16'h0000,8'd2},
        {OR,8'h32,16'h0001,8'd2},
        {OW,8'h00,16'h0098,8'd2}, {OR,8'h07,16'h0000,8'd2},   // R2 query reads zero
        {OW,8'h20,16'h0020,8'd10}, {OW,8'h20,16'h0077,8'd10}, // R10 bad confirm
        {OR,8'h00,16'h00B0,8'd10},
        {OW,8'h00,16'h0050,8'd11}, {OR,8'h00,16'h0080,8'd11},
        {OW,8'h30,16'h0040,8'd8}, {OW,8'h30,16'h1234,8'd8},   // R8 program locked
        {OR,8'h00,16'h0092,8'd8}, {OW,8'h00,16'h00FF,8'd8},
        {OR,8'h30,16'hFFFF,8'd8}, {OW,8'h00,16'h0050,8'd11}
    };

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1;  bus_addr = a;  bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        n_cmp++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic settle();
        repeat (OP_CYC + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(8'h00, 16'hFFFF, "R1");
        chk(8'h3F, 16'hFFFF, "R1");
        wr(8'h00, 16'h0070);
        chk(8'h00, 16'h0080, "R1");
        wr(8'h00, 16'h0090);
        chk(8'h02, 16'h0001, "R1");
        wr(8'h00, 16'h00FF);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][33:32])
                OW: wr(VEC[i][31:24], VEC[i][23:8]);
                OS: begin wr(VEC[i][31:24], VEC[i][23:8]); settle(); end
                default: chk(VEC[i][31:24], VEC[i][23:8], $sformatf("R%0d", VEC[i][7:0]));
            endcase
        end

        // R4: exact busy window, one read per cycle
        wr(8'h15, 16'h0040);
        wr(8'h15, 16'h1357);
        for (int c = 0; c < OP_CYC; c++) chk(8'h00, 16'h0000, "R4");
        chk(8'h00, 16'h0080, "R4");
        // R4: FFh while busy is ignored, status mode stays
        wr(8'h14, 16'h0040);
        wr(8'h14, 16'h5A5A);
        wr(8'h00, 16'h00FF);
        chk(8'h00, 16'h0000, "R4");
        settle();
        chk(8'h00, 16'h0080, "R4");
        wr(8'h00, 16'h00FF);
        chk(8'h14, 16'h5A5A, "R3");

        // R12 / R13: suspend an erase, refuse blank check, resume
        wr(8'h10, 16'h0020);
        wr(8'h10, 16'h00D0);
        wr(8'h00, 16'h00B0);
        chk(8'h00, 16'h00C0, "R12");
        repeat (10) @(negedge clk);
        wr(8'h20, 16'h00BC);
        chk(8'h00, 16'h00F0, "R13");
        wr(8'h00, 16'h0050);
        chk(8'h00, 16'h00C0, "R11");
        wr(8'h10, 16'h00D0);
        chk(8'h00, 16'h0000, "R12");
        settle();
        chk(8'h00, 16'h0080, "R12");
        wr(8'h00, 16'h00FF);
        chk(8'h14, 16'hFFFF, "R7");

        // R6: write outside the target block aborts buffered program
        wr(8'h20, 16'h00E8);
        wr(8'h20, 16'h0001);
        wr(8'h21, 16'h5555);
        wr(8'h35, 16'h6666);
        chk(8'h00, 16'h0090, "R6");
        wr(8'h00, 16'h00FF);
        chk(8'h21, 16'hFFFF, "R6");
        wr(8'h00, 16'h0050);

        // R5: count beyond block size
        wr(8'h20, 16'h00E8);
        wr(8'h20, 16'h0010);
        chk(8'h00, 16'h00B0, "R5");
        wr(8'h00, 16'h0050);

        // R8: lock-down blocks unlock; erase of locked block errors
        wr(8'h30, 16'h0060);
        wr(8'h30, 16'h002F);
        wr(8'h30, 16'h0060);
        wr(8'h30, 16'h00D0);
        wr(8'h00, 16'h0090);
        chk(8'h32, 16'h0003, "R8");
        wr(8'h30, 16'h0020);
        wr(8'h30, 16'h00D0);
        chk(8'h00, 16'h00A2, "R8");
        wr(8'h00, 16'h0050);

        // R14: configuration word from the address bus
        wr(8'h5A, 16'h0060);
        wr(8'h5A, 16'h0003);
        wr(8'h00, 16'h0090);
        chk(8'h05, 16'h005A, "R14");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule